// File: doc/BRIEF.md
# Burst-Mode 8b/10b Receive Word Aligner

This block sits between a 1:10 deserializer and an 8b/10b decoder on a link that carries traffic in bursts. Each burst opens with a training run: a single zero-disparity codeword sent back to back for a fixed time. The same run serves clock recovery and word alignment. While it is hunting, the block keeps the previous raw word next to the current one. It tests every bit rotation of that window against the training codeword in parallel and locks once one rotation has matched on several consecutive cycles.

After lock the rotation is frozen. The block waits for the first aligned word that is not the training codeword. It then enables the decoder and from that point delivers one aligned word per cycle. The decoder reports back on each word it is given, with a code-valid flag and an end-of-packet flag. An end of packet or an invalid codeword sends the block back to hunting for the next burst. A long loss of signal parks the block with both the search and the decoder disabled. Whenever the decoder is off, its input word is held so that it does not toggle.

Top module: `burst_rx_aligner`

## Requirements
- R1: While reset is asserted and directly after it, `aligner_en`, `dec_en` and `aligned` are all low.
- R2: In the parked state (all three flags low), a high `sig_present` makes `aligner_en` high after the next clock edge.
- R3: `rx_bits[9]` is the earliest received bit. The search window is the previous word concatenated above the current word. Rotation k (0 to 9) compares the 10 window bits starting k bits below the top with the training codeword. When the burst stream starts at bit s of a received word, the reported `align_ofs` is (10 - s) mod 10. On lock, `aligned` rises, `aligner_en` falls, and `align_ofs` stays constant for as long as `aligned` is high.
- R4: Lock is declared on the edge that ends the fourth consecutive cycle with a match at the same rotation. For every slip from 0 to 9 this is within 8 words of the training run.
- R5: After lock and while the aligned word still equals the training codeword, `dec_en` stays low. The first aligned word that differs raises `dec_en` with `word_out` equal to that word.
- R6: While `dec_en` is high, `word_out` carries the burst's words in order at the frozen rotation. A word equal to the training codeword inside the burst is passed through like any other word.
- R7: While `dec_en` is low, `word_out` holds its value.
- R8: If `pkt_end` is high while `dec_en` is high, the next cycle shows `dec_en` and `aligned` low and `aligner_en` high.
- R9: If `code_ok` is low while `dec_en` is high, the block returns to hunting exactly as in R8.
- R10: After `IDLE_CYC` (default 16) consecutive clock edges with `sig_present` low, `aligner_en` and `dec_en` are both low, from any state. After one edge fewer, the enable that was active is still high.
- R11: `dec_en` and `aligner_en` are never high together, and `dec_en` is high only while `aligned` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bits | input | 10 | Raw deserialized word, bit 9 received first |
| sig_present | input | 1 | Receiver sees an incoming signal |
| code_ok | input | 1 | Decoder judges `word_out` a legal codeword |
| pkt_end | input | 1 | Decoder sees `word_out` as the last word of the packet |
| word_out | output | 10 | Aligned word to the decoder |
| dec_en | output | 1 | Decoder enable; `word_out` is a burst word |
| aligner_en | output | 1 | Boundary search running |
| aligned | output | 1 | Rotation locked |
| align_ofs | output | 4 | Locked rotation, 0 to 9 |

## Verification
The properties assume that `code_ok` and `pkt_end` describe the word currently on `word_out`, and that the training codeword does not equal any of its own bit rotations, so only one rotation can lock. The bench meets both assumptions. Its decoder stand-in derives the two flags from `word_out` itself. Its only training word is 1100000111, whose single run of five zeros makes every rotation distinct. The bench also keeps the data words different from the training codeword at the start of each burst. Each burst begins from a zero-filled gap, so no partial training pattern can match before the run starts.

// File: rtl/burst_rx_aligner.sv
module burst_rx_aligner #(
  parameter int WW = 10,
  parameter logic [WW-1:0] PREAMBLE = 10'b1100000111,
  parameter int LOCK_CNT = 4,
  parameter int IDLE_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WW-1:0]           rx_bits,
  input  logic                    sig_present,
  input  logic                    code_ok,
  input  logic                    pkt_end,
  output logic [WW-1:0]           word_out,
  output logic                    dec_en,
  output logic                    aligner_en,
  output logic                    aligned,
  output logic [$clog2(WW)-1:0]   align_ofs
);

  localparam int OW = $clog2(WW);
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_SYNC, ST_DATA} st_t;

  st_t              st_q, st_nxt;
  logic [WW-1:0]    prev_q, word_q, aw;
  logic [2*WW-2:0]  win;
  logic [WW-1:0]    slc [WW];
  logic [WW-1:0]    match, lock_hit;
  logic [OW-1:0]    ofs_q, pick;
  logic [IW-1:0]    idle_q;
  logic             any_lock, timeout, hunting;

  assign win      = {prev_q, rx_bits[WW-1:1]};
  assign any_lock = |lock_hit;
  assign hunting  = (st_q == ST_HUNT) && (st_nxt == ST_HUNT);
  assign aw       = slc[ofs_q];
  assign timeout  = !sig_present && (st_q != ST_IDLE) && (idle_q == IW'(IDLE_CYC - 1));

  for (genvar k = 0; k < WW; k++) begin : g_ofs
    logic [CW-1:0] cnt_q;
    assign slc[k]      = win[2*WW-2-k -: WW];
    assign match[k]    = (slc[k] == PREAMBLE);
    assign lock_hit[k] = match[k] && (cnt_q == CW'(LOCK_CNT - 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (!hunting || !match[k]) cnt_q <= '0;
      else if (cnt_q != CW'(LOCK_CNT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    pick = '0;
    for (int k = WW - 1; k >= 0; k--)
      if (lock_hit[k]) pick = OW'(k);
  end

  always_comb begin
    st_nxt = st_q;
    if (timeout) st_nxt = ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (sig_present)         st_nxt = ST_HUNT;
        ST_HUNT: if (any_lock)            st_nxt = ST_SYNC;
        ST_SYNC: if (aw != PREAMBLE)      st_nxt = ST_DATA;
        ST_DATA: if (pkt_end || !code_ok) st_nxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prev_q <= '0;
      word_q <= '0;
      ofs_q  <= '0;
      idle_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q != ST_IDLE || sig_present) prev_q <= rx_bits;
      if (st_nxt == ST_DATA) word_q <= aw;
      if (st_q == ST_HUNT && st_nxt == ST_SYNC) ofs_q <= pick;
      if (sig_present || st_q == ST_IDLE) idle_q <= '0;
      else if (idle_q != IW'(IDLE_CYC))   idle_q <= idle_q + 1'b1;
    end
  end

  assign word_out   = word_q;
  assign dec_en     = (st_q == ST_DATA);
  assign aligner_en = (st_q == ST_HUNT);
  assign aligned    = (st_q == ST_SYNC) || (st_q == ST_DATA);
  assign align_ofs  = ofs_q;

endmodule

// File: rtl/burst_rx_aligner_chk.sv
module burst_rx_aligner_chk #(
  parameter int WW = 10,
  parameter int IDLE_CYC = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sig_present,
  input logic                  code_ok,
  input logic                  pkt_end,
  input logic [WW-1:0]         word_out,
  input logic                  dec_en,
  input logic                  aligner_en,
  input logic                  aligned,
  input logic [$clog2(WW)-1:0] align_ofs
);

  localparam int LW = $clog2(IDLE_CYC + 1);
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       lo_cnt <= '0;
    else if (sig_present)             lo_cnt <= '0;
    else if (lo_cnt != LW'(IDLE_CYC)) lo_cnt <= lo_cnt + 1'b1;
  end

  // R11
  excl_en_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dec_en && aligner_en));
  // R11
  dec_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) dec_en |-> aligned);
  // R3
  ofs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && $past(aligned)) |-> $stable(align_ofs));
  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n) !dec_en |-> $stable(word_out));
  // R8
  pkt_end_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && pkt_end) |=> (!dec_en && !aligned));
  // R9
  bad_code_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !code_ok) |=> (!dec_en && !aligned));
  // R10
  sig_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt == LW'(IDLE_CYC)) |-> (!dec_en && !aligner_en));
  // R2
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!dec_en && !aligner_en && !aligned) && $past(sig_present)) |-> aligner_en);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |-> (!dec_en && !aligner_en && !aligned));

endmodule

bind burst_rx_aligner burst_rx_aligner_chk #(.WW(WW), .IDLE_CYC(IDLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_present(sig_present), .code_ok(code_ok),
  .pkt_end(pkt_end), .word_out(word_out), .dec_en(dec_en),
  .aligner_en(aligner_en), .aligned(aligned), .align_ofs(align_ofs)
);

// File: tb/test_burst_rx_aligner.sv
`timescale 1ns/100ps
module test_burst_rx_aligner;
  localparam int WW = 10;
  localparam int IDLE_CYC = 16;
  localparam int LOCK_CNT = 4;
  localparam logic [9:0] PRE   = 10'b1100000111;
  localparam logic [9:0] END_W = 10'b0011111000;
  localparam logic [9:0] BAD_W = 10'b1111111111;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] rx_bits = '0;
  logic       sig_present = 1'b0;
  logic       code_ok, pkt_end;
  logic [9:0] word_out;
  logic       dec_en, aligner_en, aligned;
  logic [3:0] align_ofs;

  int checks = 0, errors = 0;
  logic [9:0] expq[$];
  bit sb_on = 1'b1;
  bit strm[$];

  always #2.5 clk = ~clk;

  assign code_ok = (word_out != BAD_W);
  assign pkt_end = (word_out == END_W);

  burst_rx_aligner #(.WW(WW), .PREAMBLE(PRE), .LOCK_CNT(LOCK_CNT), .IDLE_CYC(IDLE_CYC)) i_burst_rx_aligner (
    .clk(clk), .rst_n(rst_n), .rx_bits(rx_bits), .sig_present(sig_present),
    .code_ok(code_ok), .pkt_end(pkt_end), .word_out(word_out), .dec_en(dec_en),
    .aligner_en(aligner_en), .aligned(aligned), .align_ofs(align_ofs)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_word(logic [9:0] w);
    for (int i = WW - 1; i >= 0; i--) strm.push_back(w[i]);
  endtask

  // monitor / scoreboard
  bit         term_pend = 1'b0;
  string      term_req;
  logic [9:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (term_pend) begin
        term_pend = 1'b0;
        chk(!dec_en && aligner_en && !aligned, term_req, "back to hunt",
            {dec_en, aligner_en, aligned}, 3'b010);
        chk(word_out == held, "R7", "held word", word_out, held);
      end
      chk(!(dec_en && aligner_en), "R11", "enables exclusive", {dec_en, aligner_en}, 0);
      if (dec_en && sb_on) begin
        if (expq.size() == 0) chk(1'b0, "R6", "unexpected word", word_out, 0);
        else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk(word_out == e, "R6", "burst word", word_out, e);
        end
      end
      if (dec_en && (pkt_end || !code_ok)) begin
        term_pend = 1'b1;
        term_req  = pkt_end ? "R8" : "R9";
        held      = word_out;
      end
    end
  end

  // kind 0: ends with end-of-packet, 1: invalid code mid-burst, 2: signal lost in data
  task automatic burst(int s, int npre, int kind);
    logic [9:0] data [5];
    int  p, n, n0;
    bit  locked;
    data = '{10'h155, PRE, 10'h2AA, 10'h0F3, 10'h1C6};
    locked = 1'b0;
    strm.delete();
    repeat (2) push_word('0);
    repeat (npre) push_word(PRE);
    sb_on = (kind != 2);
    for (int j = 0; j < 5; j++) begin
      if (kind == 1 && j == 2) begin
        push_word(BAD_W);
        expq.push_back(BAD_W);
      end
      push_word(data[j]);
      if (kind == 0 || (kind == 1 && j < 2)) expq.push_back(data[j]);
    end
    if (kind == 0) begin
      push_word(END_W);
      expq.push_back(END_W);
    end
    repeat (3) push_word('0);
    n0 = (s == 0) ? 3 : 2;
    p = s;
    n = 0;
    while (p + WW <= strm.size()) begin
      @(negedge clk);
      if (n == 1) chk(aligner_en, "R2", "hunt after signal", aligner_en, 1);
      if (!locked && aligned) begin
        locked = 1'b1;
        chk(n == n0 + 4, "R4", "lock word index", n, n0 + 4);
        chk(align_ofs == 4'((10 - s) % 10), "R3", "offset", align_ofs, (10 - s) % 10);
        chk(!aligner_en, "R3", "search stops on lock", aligner_en, 0);
        if (npre > LOCK_CNT) chk(!dec_en, "R5", "decoder off in training", dec_en, 0);
      end
      for (int i = 0; i < WW; i++) rx_bits[WW-1-i] = strm[p+i];
      sig_present = 1'b1;
      p += WW;
      n++;
    end
    chk(locked, "R4", "lock reached", locked, 1);
    @(negedge clk);
    if (kind == 2) begin
      chk(dec_en, "R10", "data before loss", dec_en, 1);
      rx_bits = 10'h155;
    end else begin
      chk(expq.size() == 0, "R6", "words outstanding", expq.size(), 0);
      rx_bits = '0;
    end
    sig_present = 1'b0;
    repeat (IDLE_CYC - 1) @(negedge clk);
    if (kind == 2) chk(dec_en, "R10", "decoder on one edge early", dec_en, 1);
    else           chk(aligner_en, "R10", "search on one edge early", aligner_en, 1);
    @(negedge clk);
    chk(!dec_en && !aligner_en, "R10", "parked after timeout", {dec_en, aligner_en}, 0);
    sb_on = 1'b1;
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!aligner_en && !dec_en && !aligned, "R1", "in reset", {aligner_en, dec_en, aligned}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!aligner_en && !dec_en && !aligned, "R1", "after reset", {aligner_en, dec_en, aligned}, 0);
    for (int s = 0; s < WW; s++) burst(s, 8, 0);
    burst(3, 4, 0);
    burst(5, 8, 1);
    burst(0, 8, 1);
    burst(7, 8, 2);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule